// File: doc/BRIEF.md
# Oscillator Band Search Controller

This controller chooses one of eight oscillator bands for a PLL whose VCO is split into switched tanks. Software or a sequencer pulses `start` with a first-guess band on `init_band`. The controller loads that band and waits `settle_cycles` clocks for the loop to respond. It then samples two feedback flags from the analog side, a lock indicator and a tuning-voltage over/under indicator. From those two flags it either accepts the band or moves one band toward the side the tuning voltage points to. It repeats this until it finds lock or reaches a dead end.

Band code 0 is the lowest-frequency tank and the all-ones code is the highest. The search has two dead ends. One is stepping past either end of the band range. The other is a second change of direction, which means the loop keeps bouncing between neighbouring bands. Both end the search with `fail` set, so a marginal loop cannot make the controller oscillate forever. The band code also comes out packed into the oscillator setup byte, next to the two charge-pump current codes, ready for the neighbouring register that programs the analog block.

All pins are plain control and status. There is no streaming data path, so there is no valid/ready handshake and no back-pressure to honour.

Top module: `band_search_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `band_code` is 0 and `busy`, `done` and `fail` are all 0.
- R2: A `start` pulse seen while idle (busy 0) loads `init_band` into `band_code` and sets `busy` 1, `done` 0 and `fail` 0 at the next clock edge. A `start` seen while busy has no effect on the band, the timing or the result.
- R3: After every band load, `lock_in` and `over_in` are sampled only at the edge that comes `settle_cycles`+1 clocks after the load. Flag values at any other edge are ignored, so a search that makes k evaluations raises `done` exactly k*(`settle_cycles`+1) edges after the start edge.
- R4: When `lock_in` is 1 at an evaluation, the current band is accepted whatever `over_in` shows. `done` is set and `fail` stays 0.
- R5: When `lock_in` is 0 at an evaluation, `over_in`=0 (under) moves the band to the next lower code and `over_in`=1 (over) moves it to the next higher code. Code 000 is the lowest-frequency band and 111 the highest.
- R6: An evaluation that would step below 000 or above 111 ends the search with `done` and `fail` both 1, and the band is held at that limit.
- R7: An evaluation that would reverse the step direction for the second time in one search, without lock, ends the search with `done` and `fail` both 1. The band is held at the band just evaluated.
- R8: `done` rises in the same cycle that `busy` falls and the final band is shown. `done`, `fail` and `band_code` then hold until the next accepted `start`, which clears `done` and `fail`.
- R9: `setup_word` carries `band_code` in bits 7:5, 0 in bit 4, `pump1_sel` in bits 3:2 and `pump2_sel` in bits 1:0. Each 2-bit pump code selects one of four charge-pump currents, 00 the lowest and 11 the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (only acted on while idle) |
| init_band | input | 3 | First band to try |
| settle_cycles | input | 8 | Clocks to wait after each band load before sampling the flags |
| lock_in | input | 1 | PLL lock indicator |
| over_in | input | 1 | Tuning voltage indicator: 1 over (go higher), 0 under (go lower) |
| pump1_sel | input | 2 | Charge-pump current code, first loop |
| pump2_sel | input | 2 | Charge-pump current code, second loop |
| band_code | output | 3 | Selected oscillator band |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search ended, result valid |
| fail | output | 1 | Search ended without lock |
| setup_word | output | 8 | Packed oscillator setup byte |

## Verification
The bench builds the block with its defaults: a 3-bit band code, an 8-bit settle counter and a limit of two reversals. With eight bands, both range limits can be reached within a handful of evaluations from any start code. With a reversal limit of two, a plant that flips its over/under answer around one band trips the bounce guard after three or four evaluations. The run-time settle input is varied between 0 and 10. This covers back-to-back evaluations, and it leaves wide enough windows to inject stray lock pulses and a second start while the controller waits.

// File: rtl/bsearch_pkg.sv
package bsearch_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_SEARCH} srch_state_e;
  typedef enum logic [1:0] {DIR_NONE, DIR_DOWN, DIR_UP} step_dir_e;
endpackage

// File: rtl/bsc_settle_timer.sv
module bsc_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  // Down-counter: reload on every band change, then count to zero and stop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/bsc_band_reg.sv
module bsc_band_reg #(
  parameter int BAND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BAND_W-1:0] load_val,
  input  logic              step_en,
  input  logic              step_up,
  output logic [BAND_W-1:0] band,
  output logic              at_floor,
  output logic              at_ceiling
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        band <= '0;
    else if (load)     band <= load_val;
    else if (step_en)  band <= step_up ? band + 1'b1 : band - 1'b1;
  end

  assign at_floor   = (band == '0);
  assign at_ceiling = &band;
endmodule

// File: rtl/bsc_reversal_guard.sv
module bsc_reversal_guard
  import bsearch_pkg::*;
#(
  parameter int MAX_REV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic note_en,
  input  logic dir_up,
  output logic trip
);
  localparam int CW = $clog2(MAX_REV + 1);

  step_dir_e       last_dir;
  logic [CW-1:0]   rev_cnt;
  logic            reversal;
  step_dir_e       new_dir;

  assign new_dir  = dir_up ? DIR_UP : DIR_DOWN;
  assign reversal = (last_dir != DIR_NONE) && (last_dir != new_dir);
  // The decision now being made would be the MAX_REV-th reversal.
  assign trip     = reversal && (rev_cnt == CW'(MAX_REV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_dir <= DIR_NONE;
      rev_cnt  <= '0;
    end else if (clear) begin
      last_dir <= DIR_NONE;
      rev_cnt  <= '0;
    end else if (note_en) begin
      last_dir <= new_dir;
      if (reversal) rev_cnt <= rev_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/band_search_ctrl.sv
module band_search_ctrl
  import bsearch_pkg::*;
#(
  parameter int BAND_W   = 3,
  parameter int SETTLE_W = 8,
  parameter int CP_W     = 2,
  parameter int MAX_REV  = 2,
  localparam int WORD_W  = BAND_W + 1 + 2 * CP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [BAND_W-1:0]   init_band,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                lock_in,
  input  logic                over_in,
  input  logic [CP_W-1:0]     pump1_sel,
  input  logic [CP_W-1:0]     pump2_sel,
  output logic [BAND_W-1:0]   band_code,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [WORD_W-1:0]   setup_word
);
  srch_state_e state;
  logic settled, at_floor, at_ceiling, trip;
  logic take_start, evaluate, blocked, accept, abort, do_step;

  assign take_start = start && (state == ST_IDLE);
  assign evaluate   = (state == ST_SEARCH) && settled;
  assign blocked    = over_in ? at_ceiling : at_floor;
  assign accept     = evaluate && lock_in;
  assign abort      = evaluate && !lock_in && (blocked || trip);
  assign do_step    = evaluate && !lock_in && !blocked && !trip;

  bsc_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_start || do_step),
    .load_val (settle_cycles),
    .expired  (settled)
  );

  bsc_band_reg #(.BAND_W(BAND_W)) u_band (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take_start),
    .load_val   (init_band),
    .step_en    (do_step),
    .step_up    (over_in),
    .band       (band_code),
    .at_floor   (at_floor),
    .at_ceiling (at_ceiling)
  );

  bsc_reversal_guard #(.MAX_REV(MAX_REV)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (take_start),
    .note_en (do_step),
    .dir_up  (over_in),
    .trip    (trip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (take_start) begin
          state <= ST_SEARCH;
          done  <= 1'b0;
          fail  <= 1'b0;
        end
        ST_SEARCH: if (accept || abort) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          fail  <= abort;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state == ST_SEARCH);
  assign setup_word = {band_code, 1'b0, pump1_sel, pump2_sel};
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int BAND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [BAND_W-1:0] band
);
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !fail)); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (({1'b0, band} == {1'b0, $past(band)}) ||
                               ({1'b0, band} == {1'b0, $past(band)} + 1'b1) ||
                               ({1'b0, $past(band)} == {1'b0, band} + 1'b1))); // R5

  AST_FAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && !busy)); // R6

  AST_END_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(band) && $stable(fail))); // R8

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R8
endmodule

bind band_search_ctrl bsc_checker #(.BAND_W(BAND_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .fail  (fail),
  .band  (band_code)
);

// File: tb/sim_band_search_ctrl.sv
module sim_band_search_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] init_band = '0;
  logic [7:0] settle_cycles = '0;
  logic       lock_in, over_in;
  logic [1:0] pump1_sel = 2'b10, pump2_sel = 2'b01;
  logic [2:0] band_code;
  logic       busy, done, fail;
  logic [7:0] setup_word;

  // plant model: mode 0 lock at target, 1 always under, 2 always over,
  // 3 over when band<=target (never locks), 4 lock at target with over=1
  logic [2:0] p_mode = '0, p_target = '0;
  logic       lock_force = 1'b0;
  logic       lk, ov;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  band_search_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .init_band(init_band),
    .settle_cycles(settle_cycles), .lock_in(lock_in), .over_in(over_in),
    .pump1_sel(pump1_sel), .pump2_sel(pump2_sel), .band_code(band_code),
    .busy(busy), .done(done), .fail(fail), .setup_word(setup_word)
  );

  always_comb begin
    case (p_mode)
      3'd0:    begin lk = (band_code == p_target); ov = (band_code < p_target);  end
      3'd1:    begin lk = 1'b0; ov = 1'b0; end
      3'd2:    begin lk = 1'b0; ov = 1'b1; end
      3'd3:    begin lk = 1'b0; ov = (band_code <= p_target); end
      default: begin lk = (band_code == p_target); ov = 1'b1; end
    endcase
  end
  assign lock_in = lk | lock_force;
  assign over_in = ov;

  typedef struct packed {
    logic [2:0] init;
    logic [2:0] target;
    logic [2:0] mode;
    logic [7:0] settle;
    logic [2:0] exp_band;
    logic       exp_fail;
    logic [7:0] exp_cyc;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{3'd2, 3'd6, 3'd0, 8'd0, 3'd6, 1'b0, 8'd5},   // R5 upward walk
    '{3'd7, 3'd1, 3'd0, 8'd3, 3'd1, 1'b0, 8'd28},  // R5 downward walk
    '{3'd4, 3'd4, 3'd0, 8'd2, 3'd4, 1'b0, 8'd3},   // R4 immediate lock
    '{3'd5, 3'd5, 3'd4, 8'd1, 3'd5, 1'b0, 8'd2},   // R4 lock wins over "over"
    '{3'd2, 3'd0, 3'd1, 8'd1, 3'd0, 1'b1, 8'd6},   // R6 floor
    '{3'd5, 3'd0, 3'd2, 8'd0, 3'd7, 1'b1, 8'd3},   // R6 ceiling
    '{3'd0, 3'd0, 3'd1, 8'd4, 3'd0, 1'b1, 8'd5},   // R6 floor at first look
    '{3'd3, 3'd3, 3'd3, 8'd2, 3'd3, 1'b1, 8'd9},   // R7 bounce from 3
    '{3'd5, 3'd3, 3'd3, 8'd0, 3'd4, 1'b1, 8'd4}    // R7 bounce after descent
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [2:0] ib, input logic [7:0] st);
    @(negedge clk);
    init_band = ib; settle_cycles = st; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(band_code == 3'd0 && !busy && !done && !fail, "R1 in reset", band_code, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(band_code == 3'd0 && !busy && !done && !fail, "R1 after reset",
        {busy, done, fail}, 0);

    // table walk
    for (int i = 0; i < 9; i++) begin
      p_mode = VECS[i].mode; p_target = VECS[i].target;
      kick(VECS[i].init, VECS[i].settle);
      chk(busy && !done && band_code == VECS[i].init, "R2 load", band_code, VECS[i].init);
      wait_done(n);
      chk(n == int'(VECS[i].exp_cyc), "R3 cycles to done", n, VECS[i].exp_cyc);
      chk(band_code == VECS[i].exp_band, "R5/R6/R7 final band", band_code, VECS[i].exp_band);
      chk(fail == VECS[i].exp_fail, "R4/R6/R7 fail flag", fail, VECS[i].exp_fail);
      chk(!busy, "R8 busy low at done", busy, 0);
    end

    // R2 restart clears a previous fail; R3 stray lock ignored; R2 start while busy ignored
    p_mode = 3'd0; p_target = 3'd6;
    kick(3'd2, 8'd10);
    chk(!fail && !done && busy, "R2 restart clears result", {fail, done}, 0);
    n = 0;
    while (!done && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 3) lock_force = 1'b1;
      if (n == 7) lock_force = 1'b0;
      if (n == 4) begin start = 1'b1; init_band = 3'd0; end
      if (n == 5) start = 1'b0;
      if (n == 8) chk(band_code == 3'd2 && busy, "R2 start while busy ignored", band_code, 2);
    end
    chk(n == 55, "R3 settle window with stray lock", n, 55);
    chk(band_code == 3'd6 && !fail, "R3 band after stray lock", band_code, 6);

    // R8 hold, R9 packing
    repeat (20) @(negedge clk);
    chk(done && !busy && band_code == 3'd6, "R8 result held", band_code, 6);
    chk(setup_word == 8'hC9, "R9 setup word", setup_word, 8'hC9);
    pump1_sel = 2'b11; pump2_sel = 2'b00;
    @(negedge clk);
    chk(setup_word == 8'hCC, "R9 setup word pumps", setup_word, 8'hCC);

    // R8 next start clears done
    p_mode = 3'd0; p_target = 3'd1;
    kick(3'd1, 8'd0);
    chk(!done && busy, "R8 done cleared by start", done, 0);
    wait_done(n);
    chk(n == 1 && band_code == 3'd1, "R4 lock on first look", n, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule